// File: doc/BRIEF.md
# FIFO-buffered SPI master

This block is an SPI master for a system-clocked subsystem. The host writes bytes into an 8-entry transmit queue through a small register-style write port. The block serializes each byte onto MOSI, most significant bit first, in SPI mode 0. Each byte clocked in on MISO goes into an 8-entry receive queue. The host drains that queue with a pop strobe and sees its head on `rx_data`. The SCK rate is the system clock divided by an even ratio that the host programs.

Chip select has two modes. In automatic mode the block lowers CS when a transfer begins and raises it again at the first frame boundary where the transmit queue holds nothing. Software that cannot keep the queue fed therefore sees CS drop between bytes. In software mode the block leaves CS alone, and CS follows a control bit that the host sets around a transaction. A byte that arrives while the receive queue is full is lost, and a sticky error flag records the loss.

Top module: `spi_fifo_master`

## Requirements
- R1: The register at address 1 (bits 15:0) sets the SCK period in system clocks. Bit 0 is ignored, so odd values round down to even. Values 0 and 1 behave as 2. SCK stays high for half the period.
- R2: SPI mode 0. SCK is low whenever the block is idle. MOSI carries the frame MSB first and changes only on falling SCK edges or when a frame is loaded. MISO is sampled on rising SCK edges.
- R3: In automatic chip-select mode, `spi_cs_n` goes low when a transfer starts. It stays low across consecutive frames as long as the transmit queue holds data at each frame boundary.
- R4: In automatic mode, `spi_cs_n` rises at the frame boundary where the transmit queue is empty. Data written after that point starts a new CS-low period.
- R5: The control register is address 2. Bit 0 = 1 selects software chip-select mode, and bit 1 is then the level of `spi_cs_n`. In this mode `spi_cs_n` changes only on a control write, never because of a transfer.
- R6: A frame that completes while the receive queue is full is dropped, and `rx_overflow` is set. The flag stays set until the host writes 1 to bit 0 of address 3. Writing 0 there has no effect. Clearing the flag leaves the receive queue contents intact.
- R7: Writing address 0 pushes bits 7:0 into the transmit queue. A push while the queue is full is discarded. `tx_full`, `tx_empty` and `tx_level` report its occupancy.
- R8: `busy` rises in the cycle after the block sees a non-empty transmit queue while idle. It falls on the same clock edge as the final falling SCK edge of the last frame, which in automatic mode is also when CS is released. For one frame this is 16 half-periods.
- R9: After reset the state is as follows: `spi_cs_n` high, `spi_sck` low, `busy` low, both queues empty with level 0, and `rx_overflow` low.
- R10: Received bytes leave the receive queue in arrival order. `rx_data` shows the oldest byte, and `rx_pop` removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 tx data, 1 divider, 2 control, 3 error clear) |
| wr_data | input | 16 | Register write data |
| rx_pop | input | 1 | Remove the head of the receive queue |
| rx_data | output | 8 | Head of the receive queue |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| tx_level | output | 4 | Transmit queue occupancy |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_level | output | 4 | Receive queue occupancy |
| rx_overflow | output | 1 | Sticky receive-overflow flag |
| busy | output | 1 | Transfer in progress |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Master data out |
| spi_miso | input | 1 | Slave data in |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The bench runs odd, zero and minimum divider settings. A design that honoured bit 0 or stalled at zero would give the wrong SCK high width. It drives a burst that overfills the transmit queue. A design that accepted the extra byte or split the burst's CS period would show up in the captured frame count and in the CS edge counters. A byte written only after the queue ran dry must open a second CS period, which catches a design that holds CS low. The receive queue is overrun and then cleared with a zero write and a one write. A flag that is not sticky, or a clear that flushes data, changes the observed levels and bytes. Software chip-select mode is held low across an idle gap, so a design that still lets CS follow the transfer produces a rising CS edge.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

   typedef enum logic [1:0] {
      RA_TXDATA  = 2'd0,
      RA_DIVIDER = 2'd1,
      RA_CONTROL = 2'd2,
      RA_ERRCLR  = 2'd3
   } spi_reg_e;

   typedef enum logic {
      ENG_IDLE  = 1'b0,
      ENG_SHIFT = 1'b1
   } spi_eng_e;

   localparam int unsigned CTRL_SWMODE_BIT = 0;
   localparam int unsigned CTRL_CSLVL_BIT  = 1;
   localparam int unsigned ERRCLR_BIT      = 0;

endpackage

// File: rtl/spi_sync_fifo.sv
module spi_sync_fifo #(
   parameter  int unsigned WIDTH = 8,
   parameter  int unsigned DEPTH = 8,
   localparam int unsigned AW    = $clog2(DEPTH),
   localparam int unsigned LW    = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic             full,
   output logic             empty,
   output logic [LW-1:0]    level
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("spi_sync_fifo: DEPTH must be a power of two, at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("spi_sync_fifo: WIDTH must be positive");
   end

   logic [WIDTH-1:0] mem_q [DEPTH];
   logic [AW-1:0]    wr_ptr_q;
   logic [AW-1:0]    rd_ptr_q;
   logic [LW-1:0]    count_q;
   logic             do_push;
   logic             do_pop;

   assign full    = (count_q == LW'(DEPTH));
   assign empty   = (count_q == '0);
   assign level   = count_q;
   assign head    = mem_q[rd_ptr_q];
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;

   always_ff @(posedge clk) begin
      if (do_push) begin
         mem_q[wr_ptr_q] <= push_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         count_q  <= '0;
      end else begin
         if (do_push) wr_ptr_q <= wr_ptr_q + 1'b1;
         if (do_pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count_q <= count_q + 1'b1;
            2'b01:   count_q <= count_q - 1'b1;
            default: count_q <= count_q;
         endcase
      end
   end

   // A push into a full queue without a pop must be discarded.
   assert_full_discard_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> (full && $stable(level)));

   // Popping an empty queue leaves it empty.
   assert_empty_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push) |=> empty);

endmodule

// File: rtl/spi_sck_timer.sv
module spi_sck_timer #(
   parameter  int unsigned DIV_W = 16,
   localparam int unsigned HW    = DIV_W - 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [HW-1:0] half_period,
   output logic          tick
);

   if (DIV_W < 2) begin : g_bad_div
      $error("spi_sck_timer: DIV_W must be at least 2");
   end

   logic [HW-1:0] cnt_q;
   logic [HW-1:0] half_eff;

   // Ratios 0 and 1 collapse to the fastest legal rate (half period of 1).
   assign half_eff = (half_period == '0) ? HW'(1) : half_period;
   assign tick     = run && (cnt_q >= half_eff - HW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // Counter is held at zero while the engine is stopped.
   assert_idle_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt_q == '0));

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
   import spi_fifo_pkg::*;
#(
   parameter  int unsigned FRAME_W = 8,
   localparam int unsigned BCW     = $clog2(FRAME_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               tx_empty,
   input  logic [FRAME_W-1:0] tx_head,
   output logic               tx_pop,
   input  logic               rx_full,
   output logic               rx_push,
   output logic               rx_drop,
   output logic [FRAME_W-1:0] rx_frame,
   output logic               sck,
   output logic               mosi,
   input  logic               miso,
   output logic               busy
);

   if (FRAME_W < 2) begin : g_bad_frame
      $error("spi_shift_engine: FRAME_W must be at least 2");
   end

   spi_eng_e           state_q;
   logic               sck_q;
   logic [FRAME_W-1:0] tx_sh_q;
   logic [FRAME_W-1:0] rx_sh_q;
   logic [BCW-1:0]     bit_q;
   logic               last_bit;
   logic               start;
   logic               frame_end;

   assign last_bit  = (bit_q == BCW'(FRAME_W - 1));
   assign start     = (state_q == ENG_IDLE) && !tx_empty;
   assign frame_end = (state_q == ENG_SHIFT) && tick && sck_q && last_bit;

   assign tx_pop   = start || (frame_end && !tx_empty);
   assign rx_push  = frame_end && !rx_full;
   assign rx_drop  = frame_end && rx_full;
   assign rx_frame = rx_sh_q;
   assign sck      = sck_q;
   assign mosi     = tx_sh_q[FRAME_W-1];
   assign busy     = (state_q == ENG_SHIFT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ENG_IDLE;
         sck_q   <= 1'b0;
         tx_sh_q <= '0;
         rx_sh_q <= '0;
         bit_q   <= '0;
      end else begin
         case (state_q)
            ENG_IDLE: begin
               if (!tx_empty) begin
                  state_q <= ENG_SHIFT;
                  tx_sh_q <= tx_head;
                  bit_q   <= '0;
                  sck_q   <= 1'b0;
               end
            end
            ENG_SHIFT: begin
               if (tick) begin
                  if (!sck_q) begin
                     sck_q   <= 1'b1;
                     rx_sh_q <= {rx_sh_q[FRAME_W-2:0], miso};
                  end else begin
                     sck_q <= 1'b0;
                     if (last_bit) begin
                        if (!tx_empty) begin
                           tx_sh_q <= tx_head;
                           bit_q   <= '0;
                        end else begin
                           state_q <= ENG_IDLE;
                        end
                     end else begin
                        tx_sh_q <= {tx_sh_q[FRAME_W-2:0], 1'b0};
                        bit_q   <= bit_q + 1'b1;
                     end
                  end
               end
            end
            default: state_q <= ENG_IDLE;
         endcase
      end
   end

   assert_sck_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sck);

   assert_mosi_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$fell(sck)) |-> $stable(mosi));

   assert_release_when_dry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(tx_empty));

   assert_busy_ends_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(sck) && !sck));

endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
   import spi_fifo_pkg::*;
#(
   parameter  int unsigned FRAME_W    = 8,
   parameter  int unsigned FIFO_DEPTH = 8,
   parameter  int unsigned DIV_W      = 16,
   parameter  int unsigned DIV_RESET  = 4,
   localparam int unsigned LVL_W      = $clog2(FIFO_DEPTH) + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [1:0]         wr_addr,
   input  logic [DIV_W-1:0]   wr_data,
   input  logic               rx_pop,
   output logic [FRAME_W-1:0] rx_data,
   output logic               tx_full,
   output logic               tx_empty,
   output logic [LVL_W-1:0]   tx_level,
   output logic               rx_full,
   output logic               rx_empty,
   output logic [LVL_W-1:0]   rx_level,
   output logic               rx_overflow,
   output logic               busy,
   output logic               spi_sck,
   output logic               spi_mosi,
   input  logic               spi_miso,
   output logic               spi_cs_n
);

   if (DIV_W < FRAME_W || DIV_W < 2) begin : g_bad_width
      $error("spi_fifo_master: DIV_W must cover FRAME_W and be at least 2");
   end
   if (DIV_RESET >= (1 << DIV_W)) begin : g_bad_reset
      $error("spi_fifo_master: DIV_RESET does not fit in DIV_W bits");
   end

   localparam int unsigned HALF_W = DIV_W - 1;

   logic [HALF_W-1:0]  half_q;
   logic               sw_mode_q;
   logic               sw_cs_q;
   logic               err_q;

   logic               wr_tx;
   logic               wr_div;
   logic               wr_ctl;
   logic               wr_clr;
   logic               tick;
   logic               eng_busy;
   logic               tx_pop;
   logic [FRAME_W-1:0] tx_head;
   logic               rx_push;
   logic               rx_drop;
   logic [FRAME_W-1:0] rx_frame;

   assign wr_tx  = wr_en && (wr_addr == RA_TXDATA);
   assign wr_div = wr_en && (wr_addr == RA_DIVIDER);
   assign wr_ctl = wr_en && (wr_addr == RA_CONTROL);
   assign wr_clr = wr_en && (wr_addr == RA_ERRCLR) && wr_data[ERRCLR_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_q    <= HALF_W'(DIV_RESET >> 1);
         sw_mode_q <= 1'b0;
         sw_cs_q   <= 1'b1;
         err_q     <= 1'b0;
      end else begin
         if (wr_div) half_q <= wr_data[DIV_W-1:1];
         if (wr_ctl) begin
            sw_mode_q <= wr_data[CTRL_SWMODE_BIT];
            sw_cs_q   <= wr_data[CTRL_CSLVL_BIT];
         end
         if (rx_drop)     err_q <= 1'b1;
         else if (wr_clr) err_q <= 1'b0;
      end
   end

   spi_sync_fifo #(.WIDTH(FRAME_W), .DEPTH(FIFO_DEPTH)) tx_fifo_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (wr_tx),
      .push_data (wr_data[FRAME_W-1:0]),
      .pop       (tx_pop),
      .head      (tx_head),
      .full      (tx_full),
      .empty     (tx_empty),
      .level     (tx_level)
   );

   spi_sync_fifo #(.WIDTH(FRAME_W), .DEPTH(FIFO_DEPTH)) rx_fifo_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (rx_push),
      .push_data (rx_frame),
      .pop       (rx_pop),
      .head      (rx_data),
      .full      (rx_full),
      .empty     (rx_empty),
      .level     (rx_level)
   );

   spi_sck_timer #(.DIV_W(DIV_W)) timer_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (eng_busy),
      .half_period (half_q),
      .tick        (tick)
   );

   spi_shift_engine #(.FRAME_W(FRAME_W)) engine_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .tx_empty (tx_empty),
      .tx_head  (tx_head),
      .tx_pop   (tx_pop),
      .rx_full  (rx_full),
      .rx_push  (rx_push),
      .rx_drop  (rx_drop),
      .rx_frame (rx_frame),
      .sck      (spi_sck),
      .mosi     (spi_mosi),
      .miso     (spi_miso),
      .busy     (eng_busy)
   );

   assign busy        = eng_busy;
   assign rx_overflow = err_q;
   assign spi_cs_n    = sw_mode_q ? sw_cs_q : !eng_busy;

   assert_sw_cs_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_mode_q && !wr_ctl) |=> $stable(spi_cs_n));

   assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_overflow && !wr_clr) |=> rx_overflow);

endmodule

// File: tb/spi_fifo_master_tb_top.sv
module spi_fifo_master_tb_top;
   import spi_fifo_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = 2'd0;
   logic [15:0] wr_data = 16'd0;
   logic        rx_pop = 1'b0;
   logic [7:0]  rx_data;
   logic        tx_full, tx_empty, rx_full, rx_empty, rx_overflow, busy;
   logic [3:0]  tx_level, rx_level;
   logic        spi_sck, spi_mosi, spi_miso, spi_cs_n;

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   spi_fifo_master dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rx_pop(rx_pop), .rx_data(rx_data), .tx_full(tx_full), .tx_empty(tx_empty),
      .tx_level(tx_level), .rx_full(rx_full), .rx_empty(rx_empty), .rx_level(rx_level),
      .rx_overflow(rx_overflow), .busy(busy), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
      .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
   );

   // ---------------- slave model and pin monitors ----------------
   function automatic logic [7:0] slave_byte(input int i);
      return 8'((i * 37) ^ 8'h5A);
   endfunction

   int         sidx = 0;
   int         sbits = 0;
   int         cs_falls = 0;
   int         cs_rises = 0;
   logic [7:0] sl_sh = 8'h00;
   logic [7:0] cap = 8'h00;
   logic [7:0] mlog [64];
   logic       cs_prev = 1'b1;
   logic       sck_prev = 1'b0;

   assign spi_miso = sl_sh[7];

   always @(spi_cs_n or spi_sck) begin
      if (cs_prev === 1'b1 && spi_cs_n === 1'b0) begin
         cs_falls++;
         sbits = 0;
         sl_sh = slave_byte(sidx);
      end
      if (cs_prev === 1'b0 && spi_cs_n === 1'b1) cs_rises++;
      if (spi_cs_n === 1'b0 && spi_sck === 1'b1 && sck_prev === 1'b0) begin
         cap = {cap[6:0], spi_mosi};
         sbits++;
         if (sbits == 8) begin
            mlog[sidx % 64] = cap;
            sidx++;
         end
      end
      if (spi_cs_n === 1'b0 && spi_sck === 1'b0 && sck_prev === 1'b1) begin
         if (sbits == 8) begin
            sbits = 0;
            sl_sh = slave_byte(sidx);
         end else begin
            sl_sh = {sl_sh[6:0], 1'b0};
         end
      end
      cs_prev  = spi_cs_n;
      sck_prev = spi_sck;
   end

   int hi_run = 0;
   int last_hi = 0;
   always @(negedge clk) begin
      if (spi_sck === 1'b1) hi_run++;
      else if (hi_run != 0) begin
         last_hi = hi_run;
         hi_run  = 0;
      end
   end

   // ---------------- helpers ----------------
   task automatic check_eq(input string req, input string what, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic push_burst(input int n, input logic [7:0] first);
      @(negedge clk);
      for (int k = 0; k < n; k++) begin
         wr_en = 1'b1; wr_addr = RA_TXDATA; wr_data = {8'h00, first + 8'(k)};
         @(negedge clk);
      end
      wr_en = 1'b0;
   endtask

   task automatic pop_expect(input string req, input logic [7:0] exp);
      @(negedge clk);
      check_eq(req, "rx_data", int'(rx_data), int'(exp));
      rx_pop = 1'b1;
      @(negedge clk);
      rx_pop = 1'b0;
   endtask

   task automatic wait_idle();
      int t = 0;
      repeat (2) @(negedge clk);
      while ((busy || !tx_empty) && t < 100000) begin
         @(negedge clk);
         t++;
      end
      if (t >= 100000) check_eq("R8", "idle timeout", 1, 0);
      @(negedge clk);
   endtask

   // div, expected SCK high width, byte sent
   localparam logic [31:0] VEC [6] = '{
      {16'd2,  8'd1, 8'hC3},
      {16'd3,  8'd1, 8'h81},
      {16'd7,  8'd3, 8'h3C},
      {16'd10, 8'd5, 8'hE7},
      {16'd0,  8'd1, 8'h01},
      {16'd4,  8'd2, 8'h96}
   };

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   initial begin
      int base, f0, r0, cyc;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cs_falls = 0; cs_rises = 0;

      // R9 reset state
      check_eq("R9", "cs_n", int'(spi_cs_n), 1);
      check_eq("R9", "sck", int'(spi_sck), 0);
      check_eq("R9", "busy", int'(busy), 0);
      check_eq("R9", "tx_empty", int'(tx_empty), 1);
      check_eq("R9", "rx_empty", int'(rx_empty), 1);
      check_eq("R9", "levels", int'(tx_level) + int'(rx_level), 0);
      check_eq("R9", "rx_overflow", int'(rx_overflow), 0);

      // table: divider rounding (R1), mode 0 data in both directions (R2)
      for (int i = 0; i < 6; i++) begin
         reg_write(RA_DIVIDER, VEC[i][31:16]);
         base = sidx;
         f0 = cs_falls;
         reg_write(RA_TXDATA, {8'h00, VEC[i][7:0]});
         wait_idle();
         check_eq("R1", "sck high width", last_hi, int'(VEC[i][15:8]));
         check_eq("R2", "mosi byte", int'(mlog[base % 64]), int'(VEC[i][7:0]));
         check_eq("R4", "single frame cs periods", cs_falls - f0, 1);
         check_eq("R10", "rx_level", int'(rx_level), 1);
         pop_expect("R2", slave_byte(base));
      end

      // R8 exact busy span for one frame at divider 4 (16 half-periods of 2)
      reg_write(RA_DIVIDER, 16'd4);
      reg_write(RA_TXDATA, 16'h005F);
      check_eq("R8", "busy before start", int'(busy), 0);
      @(negedge clk);
      check_eq("R8", "busy at start", int'(busy), 1);
      check_eq("R3", "cs_n low at start", int'(spi_cs_n), 0);
      check_eq("R2", "sck low at start", int'(spi_sck), 0);
      cyc = 0;
      while (busy && cyc < 1000) begin
         cyc++;
         @(negedge clk);
      end
      check_eq("R8", "busy cycles", cyc, 32);
      check_eq("R4", "cs_n released with busy", int'(spi_cs_n), 1);
      pop_expect("R10", slave_byte(sidx - 1));

      // R3 burst in one CS period, R10 order
      base = sidx; f0 = cs_falls;
      push_burst(3, 8'h11);
      wait_idle();
      check_eq("R3", "burst cs periods", cs_falls - f0, 1);
      check_eq("R3", "burst frames", sidx - base, 3);
      for (int k = 0; k < 3; k++)
         check_eq("R2", "burst mosi", int'(mlog[(base + k) % 64]), 8'h11 + k);
      for (int k = 0; k < 3; k++) pop_expect("R10", slave_byte(base + k));

      // R4 late data opens a second CS period
      base = sidx; f0 = cs_falls; r0 = cs_rises;
      reg_write(RA_TXDATA, 16'h00A1);
      wait_idle();
      repeat (3) @(negedge clk);
      reg_write(RA_TXDATA, 16'h00B2);
      wait_idle();
      check_eq("R4", "late cs falls", cs_falls - f0, 2);
      check_eq("R4", "late cs rises", cs_rises - r0, 2);
      check_eq("R4", "late byte", int'(mlog[(base + 1) % 64]), 8'hB2);
      pop_expect("R10", slave_byte(base));
      pop_expect("R10", slave_byte(base + 1));

      // R5 software chip select
      reg_write(RA_CONTROL, 16'h0003);
      check_eq("R5", "sw cs high", int'(spi_cs_n), 1);
      f0 = cs_falls;
      reg_write(RA_CONTROL, 16'h0001);
      check_eq("R5", "sw cs low", int'(spi_cs_n), 0);
      r0 = cs_rises; base = sidx;
      reg_write(RA_TXDATA, 16'h00C4);
      wait_idle();
      repeat (5) @(negedge clk);
      check_eq("R5", "cs held after frame", int'(spi_cs_n), 0);
      reg_write(RA_TXDATA, 16'h00D5);
      wait_idle();
      check_eq("R5", "no cs rise in sw mode", cs_rises - r0, 0);
      check_eq("R5", "only the written fall", cs_falls - f0, 1);
      check_eq("R5", "sw frames", int'(mlog[(base + 1) % 64]), 8'hD5);
      reg_write(RA_CONTROL, 16'h0003);
      check_eq("R5", "sw cs raised", int'(spi_cs_n), 1);
      pop_expect("R10", slave_byte(base));
      pop_expect("R10", slave_byte(base + 1));
      reg_write(RA_CONTROL, 16'h0000);
      check_eq("R3", "back to auto cs", int'(spi_cs_n), 1);

      // R7 tx full discard, R6 rx overflow
      reg_write(RA_DIVIDER, 16'd8);
      base = sidx; f0 = cs_falls;
      push_burst(10, 8'h40);
      check_eq("R7", "tx_full", int'(tx_full), 1);
      check_eq("R7", "tx_level", int'(tx_level), 8);
      wait_idle();
      check_eq("R7", "frames sent", sidx - base, 9);
      check_eq("R7", "last sent", int'(mlog[(base + 8) % 64]), 8'h48);
      check_eq("R3", "fill cs periods", cs_falls - f0, 1);
      check_eq("R6", "rx_level", int'(rx_level), 8);
      check_eq("R6", "rx_full", int'(rx_full), 1);
      check_eq("R6", "overflow set", int'(rx_overflow), 1);
      reg_write(RA_ERRCLR, 16'h0000);
      check_eq("R6", "zero write keeps flag", int'(rx_overflow), 1);
      reg_write(RA_ERRCLR, 16'h0001);
      check_eq("R6", "flag cleared", int'(rx_overflow), 0);
      check_eq("R6", "no flush", int'(rx_level), 8);
      for (int k = 0; k < 8; k++) pop_expect("R6", slave_byte(base + k));
      check_eq("R10", "rx drained", int'(rx_empty), 1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

endmodule